// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the program counter of a small 8-bit virtual-machine processor that executes 16-bit instructions over a 12-bit address space. Each time the step strobe is raised, it takes the decoded instruction word with the values read from the register file for the X field, the Y field and register 0, plus a 16-bit vector of keypad states. From these it picks the next program counter. The choices are a plain advance, an absolute jump, a jump offset by register 0, a subroutine call or return through an internal return-address stack, or a conditional skip over the following instruction.

Every instruction is two bytes long. A plain advance adds 2 and a taken skip adds 4, and all program-counter arithmetic wraps within 12 bits. A jump whose target equals its own address stops the machine. The unit then raises a sticky halt output and ignores further steps until reset. Stack misuse sets sticky indications. A call on a full stack does not store its return address but still jumps. A return on an empty stack resumes at the program load address 0x200.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset the PC is 0x200, and halt, stack_overflow and stack_underflow are all 0.
- R2: In a cycle without step, the PC and all flags keep their values. A step on any opcode not listed in R3 to R11 adds 2 to the PC modulo 4096, so 0xFFE is followed by 0x000.
- R3: Opcode 1aaa loads aaa into the PC. If aaa equals the current PC, halt rises and stays at 1. While halt is 1, steps leave the PC unchanged.
- R4: Opcode Bnnn loads (nnn + value of register 0) modulo 4096 into the PC.
- R5: Opcode 2aaa stores the return address PC+2 on the stack and loads aaa into the PC.
- R6: Opcode 00EE loads the most recently stored return address into the PC and removes it from the stack, in last-in first-out order.
- R7: Opcode 00EE on an empty stack loads 0x200 into the PC and sets the sticky stack_underflow output.
- R8: The stack holds 16 return addresses. A call made while 16 are stored keeps the stored entries unchanged, sets the sticky stack_overflow output, and still jumps to aaa.
- R9: Opcode 3xbb adds 4 when vX equals bb and 2 otherwise. Opcode 4xbb adds 4 when vX differs from bb and 2 otherwise.
- R10: Opcode 5xy0 adds 4 when vX equals vY. Opcode 9xy0 adds 4 when they differ. Otherwise these opcodes add 2. When the low nibble is not 0, the opcode is a plain advance.
- R11: Opcode Ex9E adds 4 when keys[vX & 0xF] is 1 (pressed). Opcode ExA1 adds 4 when that bit is 0. Otherwise they add 2, and any other Exxx is a plain advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Execute the presented instruction this cycle |
| insn | input | 16 | Instruction word |
| vx | input | 8 | Value of the register selected by bits 11:8 |
| vy | input | 8 | Value of the register selected by bits 7:4 |
| v0 | input | 8 | Value of register 0 |
| keys | input | 16 | Keypad state, bit i = 1 when key i is pressed |
| pc | output | 12 | Current program counter |
| halt | output | 1 | Sticky, set by a jump to its own address |
| stack_overflow | output | 1 | Sticky, set by a call on a full stack |
| stack_underflow | output | 1 | Sticky, set by a return on an empty stack |

## Verification
The assertions check the following on every cycle. The PC holds without a step and while halted. The halt and stack flags stay set once raised. Absolute jumps and calls land exactly on their target field. The stack is never written when full or popped when empty. The bench scenarios are needed for everything that depends on data or history. That covers skip decisions against immediates, registers and key bits, offset jumps that wrap, the last-in first-out order of returns across nested calls, the preserved contents after an overflowed call, and the fallback to 0x200 on underflow. A reference model in the bench tracks the same PC and stack through directed corners and a long random instruction stream.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int INSN_W = 16;
    localparam logic [ADDR_W-1:0] LOAD_ADDR = 12'h200;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_JMP,
        FLOW_JMPV0,
        FLOW_CALL,
        FLOW_RET,
        FLOW_SKIP
    } flow_e;

    typedef enum logic [2:0] {
        COND_EQ_IMM,
        COND_NE_IMM,
        COND_EQ_REG,
        COND_NE_REG,
        COND_KEY_DN,
        COND_KEY_UP
    } cond_e;

    typedef struct packed {
        flow_e              flow;
        cond_e              cond;
        logic [ADDR_W-1:0]  target;
        logic [DATA_W-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic               halt;
        logic               ovf;
        logic               unf;
    } pcb_state_t;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
    import pcb_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [3:0] op_hi;
    logic [3:0] op_lo;
    logic [7:0] op_byte;

    always_comb begin
        op_hi   = insn[15:12];
        op_lo   = insn[3:0];
        op_byte = insn[7:0];
        dec.flow   = FLOW_SEQ;
        dec.cond   = COND_EQ_IMM;
        dec.target = insn[ADDR_W-1:0];
        dec.imm    = op_byte;
        unique case (op_hi)
            4'h0: if (insn == 16'h00EE) dec.flow = FLOW_RET;
            4'h1: dec.flow = FLOW_JMP;
            4'h2: dec.flow = FLOW_CALL;
            4'h3: begin dec.flow = FLOW_SKIP; dec.cond = COND_EQ_IMM; end
            4'h4: begin dec.flow = FLOW_SKIP; dec.cond = COND_NE_IMM; end
            4'h5: if (op_lo == 4'h0) begin dec.flow = FLOW_SKIP; dec.cond = COND_EQ_REG; end
            4'h9: if (op_lo == 4'h0) begin dec.flow = FLOW_SKIP; dec.cond = COND_NE_REG; end
            4'hB: dec.flow = FLOW_JMPV0;
            4'hE: begin
                if (op_byte == 8'h9E) begin dec.flow = FLOW_SKIP; dec.cond = COND_KEY_DN; end
                else if (op_byte == 8'hA1) begin dec.flow = FLOW_SKIP; dec.cond = COND_KEY_UP; end
            end
            default: dec.flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/pcb_skip_eval.sv
module pcb_skip_eval
    import pcb_pkg::*;
#(
    parameter int KEYS = 16
) (
    input  cond_e             cond,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] vx,
    input  logic [DATA_W-1:0] vy,
    input  logic [KEYS-1:0]   keys,
    output logic              take
);
    localparam int KEY_IDX_W = $clog2(KEYS);

    logic [KEY_IDX_W-1:0] key_idx;
    logic                 key_dn;

    always_comb begin
        key_idx = vx[KEY_IDX_W-1:0];
        key_dn  = keys[key_idx];
        unique case (cond)
            COND_EQ_IMM: take = (vx == imm);
            COND_NE_IMM: take = (vx != imm);
            COND_EQ_REG: take = (vx == vy);
            COND_NE_REG: take = (vx != vy);
            COND_KEY_DN: take = key_dn;
            COND_KEY_UP: take = !key_dn;
            default:     take = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcb_ret_stack.sv
module pcb_ret_stack #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] top,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [PTR_W-1:0] wr_idx, rd_idx;

    always_comb begin
        empty  = (cnt_q == '0);
        full   = (cnt_q == CNT_W'(DEPTH));
        wr_idx = PTR_W'(cnt_q);
        rd_idx = PTR_W'(cnt_q - CNT_W'(1));
        top    = mem_q[rd_idx];
        cnt_d  = cnt_q;
        if (push && !full)
            cnt_d = cnt_q + CNT_W'(1);
        else if (pop && !empty)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
        if (push && !full) mem_q[wr_idx] <= din;
    end

    // R8: the controller never asks for a push on a full stack
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the controller never asks for a pop on an empty stack
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R6: push and pop are exclusive
    a_r6_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
    import pcb_pkg::*;
#(
    parameter int STACK_DEPTH = 16,
    parameter int KEYS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [15:0]       insn,
    input  logic [7:0]        vx,
    input  logic [7:0]        vy,
    input  logic [7:0]        v0,
    input  logic [KEYS-1:0]   keys,
    output logic [11:0]       pc,
    output logic              halt,
    output logic              stack_overflow,
    output logic              stack_underflow
);
    localparam logic [ADDR_W-1:0] INC_ONE = ADDR_W'(INSN_W / 8);
    localparam logic [ADDR_W-1:0] INC_TWO = ADDR_W'(2 * (INSN_W / 8));

    dec_t              dec;
    logic              take;
    logic              push, pop;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_empty, stk_full;
    logic [ADDR_W-1:0] ret_addr;
    pcb_state_t        st_d, st_q;

    pcb_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    pcb_skip_eval #(.KEYS(KEYS)) u_skip (
        .cond (dec.cond),
        .imm  (dec.imm),
        .vx   (vx),
        .vy   (vy),
        .keys (keys),
        .take (take)
    );

    pcb_ret_stack #(.DEPTH(STACK_DEPTH), .WIDTH(ADDR_W)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (ret_addr),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        pop      = 1'b0;
        ret_addr = st_q.pc + INC_ONE;
        if (step && !st_q.halt) begin
            unique case (dec.flow)
                FLOW_JMP: begin
                    st_d.pc = dec.target;
                    if (dec.target == st_q.pc) st_d.halt = 1'b1;
                end
                FLOW_JMPV0: st_d.pc = dec.target + ADDR_W'(v0);
                FLOW_CALL: begin
                    if (stk_full) st_d.ovf = 1'b1;
                    else          push = 1'b1;
                    st_d.pc = dec.target;
                end
                FLOW_RET: begin
                    if (stk_empty) begin
                        st_d.pc  = LOAD_ADDR;
                        st_d.unf = 1'b1;
                    end else begin
                        pop     = 1'b1;
                        st_d.pc = stk_top;
                    end
                end
                FLOW_SKIP: st_d.pc = st_q.pc + (take ? INC_TWO : INC_ONE);
                default:   st_d.pc = st_q.pc + INC_ONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= LOAD_ADDR;
            st_q.halt <= 1'b0;
            st_q.ovf  <= 1'b0;
            st_q.unf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc              = st_q.pc;
    assign halt            = st_q.halt;
    assign stack_overflow  = st_q.ovf;
    assign stack_underflow = st_q.unf;

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc) && $stable(halt));
    a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt && $stable(pc));
    a_r3_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
        step && !halt && insn[15:12] == 4'h1 |=> pc == $past(insn[11:0]));
    a_r5_call_lands: assert property (@(posedge clk) disable iff (!rst_n)
        step && !halt && insn[15:12] == 4'h2 |=> pc == $past(insn[11:0]));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_overflow |=> stack_overflow);
    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_underflow |=> stack_underflow);
    a_r2_advance_even: assert property (@(posedge clk) disable iff (!rst_n)
        step && !halt && insn[15:12] == 4'h6 |=> pc == $past(pc) + 12'd2);
endmodule

// File: tb/pc_branch_unit_test.sv
module pc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [15:0] insn = 16'h0000;
    logic [7:0]  vx = 8'h00, vy = 8'h00, v0 = 8'h00;
    logic [15:0] keys = 16'h0000;
    logic [11:0] pc;
    logic        halt, stack_overflow, stack_underflow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [11:0] m_pc;
    logic        m_halt, m_ovf, m_unf;
    logic [11:0] m_stk [16];
    int          m_cnt;

    pc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .step(step), .insn(insn),
        .vx(vx), .vy(vy), .v0(v0), .keys(keys),
        .pc(pc), .halt(halt),
        .stack_overflow(stack_overflow), .stack_underflow(stack_underflow)
    );

    always #4 clk = ~clk;

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            finish_up();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_next(input logic [15:0] i, input logic [7:0] x,
            input logic [7:0] y, input logic [7:0] z, input logic [15:0] k);
        logic [11:0] a2 = m_pc + 12'd2;
        logic [11:0] a4 = m_pc + 12'd4;
        case (i[15:12])
            4'h1: return i[11:0];
            4'h2: return i[11:0];
            4'h3: return (x == i[7:0]) ? a4 : a2;
            4'h4: return (x != i[7:0]) ? a4 : a2;
            4'h5: return (i[3:0] == 4'h0 && x == y) ? a4 : a2;
            4'h9: return (i[3:0] == 4'h0 && x != y) ? a4 : a2;
            4'hB: return i[11:0] + {4'h0, z};
            4'hE: begin
                if (i[7:0] == 8'h9E) return k[x[3:0]] ? a4 : a2;
                if (i[7:0] == 8'hA1) return !k[x[3:0]] ? a4 : a2;
                return a2;
            end
            default: return a2;
        endcase
    endfunction

    task automatic model_step(input logic [15:0] i, input logic [7:0] x,
            input logic [7:0] y, input logic [7:0] z, input logic [15:0] k);
        logic [11:0] nxt;
        if (m_halt) return;
        nxt = exp_next(i, x, y, z, k);
        if (i == 16'h00EE) begin
            if (m_cnt == 0) begin nxt = 12'h200; m_unf = 1'b1; end
            else begin m_cnt--; nxt = m_stk[m_cnt]; end
        end else if (i[15:12] == 4'h2) begin
            if (m_cnt == 16) m_ovf = 1'b1;
            else begin m_stk[m_cnt] = m_pc + 12'd2; m_cnt++; end
        end else if (i[15:12] == 4'h1 && i[11:0] == m_pc) begin
            m_halt = 1'b1;
        end
        m_pc = nxt;
    endtask

    task automatic compare_all(input string tag);
        chk(tag, {20'h0, pc}, {20'h0, m_pc});
        chk({tag, " halt"}, {31'h0, halt}, {31'h0, m_halt});
        chk({tag, " ovf"}, {31'h0, stack_overflow}, {31'h0, m_ovf});
        chk({tag, " unf"}, {31'h0, stack_underflow}, {31'h0, m_unf});
    endtask

    task automatic do_step(input string tag, input logic [15:0] i, input logic [7:0] x,
            input logic [7:0] y, input logic [7:0] z, input logic [15:0] k);
        @(negedge clk);
        insn = i; vx = x; vy = y; v0 = z; keys = k; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        model_step(i, x, y, z, k);
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = 12'h200; m_halt = 1'b0; m_ovf = 1'b0; m_unf = 1'b0; m_cnt = 0;
    endtask

    function automatic logic [15:0] rand_insn();
        logic [11:0] a;
        int r = $urandom % 12;
        a = 12'($urandom);
        if (a == m_pc) a = a + 12'd2;
        case (r)
            0: return {4'h6, a};
            1: return {4'h8, a};
            2: return {4'h1, a};
            3: return {4'hB, a};
            4: return {4'h2, a};
            5: return 16'h00EE;
            6: return {4'h3, a};
            7: return {4'h4, a};
            8: return {4'h5, a[11:4], ($urandom % 3 == 0) ? a[3:0] : 4'h0};
            9: return {4'h9, a[11:4], ($urandom % 3 == 0) ? a[3:0] : 4'h0};
            10: return {4'hE, a[11:8], ($urandom % 2 == 0) ? 8'h9E : 8'hA1};
            default: return {4'hE, a[11:8], 8'h55};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        compare_all("R1 reset");
        // R2: idle cycles hold state
        repeat (5) @(negedge clk);
        compare_all("R2 idle hold");
        do_step("R2 advance", 16'h6123, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R3 jump", 16'h1FFE, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R2 wrap", 16'h7001, 8'h00, 8'h00, 8'h00, 16'h0);
        // R4: offset jump wraps
        do_step("R4 jump plus v0", 16'hBF80, 8'h00, 8'h00, 8'hFF, 16'h0);
        // R5 / R6: nested calls then returns
        do_step("R5 call outer", 16'h2400, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R5 call inner", 16'h2500, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R6 return inner", 16'h00EE, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R6 return outer", 16'h00EE, 8'h00, 8'h00, 8'h00, 16'h0);
        // R7: return with nothing stored
        do_step("R7 underflow", 16'h00EE, 8'h00, 8'h00, 8'h00, 16'h0);
        // R9: immediate compares
        do_step("R9 eq imm taken", 16'h3A42, 8'h42, 8'h00, 8'h00, 16'h0);
        do_step("R9 eq imm not", 16'h3A42, 8'h43, 8'h00, 8'h00, 16'h0);
        do_step("R9 ne imm taken", 16'h4A42, 8'h43, 8'h00, 8'h00, 16'h0);
        do_step("R9 ne imm not", 16'h4A42, 8'h42, 8'h00, 8'h00, 16'h0);
        // R10: register compares and non-zero low nibble
        do_step("R10 eq reg taken", 16'h5120, 8'h77, 8'h77, 8'h00, 16'h0);
        do_step("R10 ne reg taken", 16'h9120, 8'h77, 8'h78, 8'h00, 16'h0);
        do_step("R10 ne reg not", 16'h9120, 8'h77, 8'h77, 8'h00, 16'h0);
        do_step("R10 low nibble", 16'h5121, 8'h77, 8'h77, 8'h00, 16'h0);
        // R11: keys, index uses low nibble only
        do_step("R11 key down taken", 16'hE39E, 8'hF5, 8'h00, 8'h00, 16'h0020);
        do_step("R11 key down not", 16'hE39E, 8'hF5, 8'h00, 8'h00, 16'hFFDF);
        do_step("R11 key up taken", 16'hE3A1, 8'h05, 8'h00, 8'h00, 16'hFFDF);
        do_step("R11 key up not", 16'hE3A1, 8'h05, 8'h00, 8'h00, 16'h0020);
        do_step("R11 other E op", 16'hE355, 8'h05, 8'h00, 8'h00, 16'hFFFF);

        // R8: fill stack, overflow, then drain and underflow
        do_reset();
        for (int n = 0; n < 17; n++)
            do_step("R8 fill call", 16'h2300, 8'h00, 8'h00, 8'h00, 16'h0);
        for (int n = 0; n < 17; n++)
            do_step("R8 drain return", 16'h00EE, 8'h00, 8'h00, 8'h00, 16'h0);

        // R3: jump to self halts and freezes
        do_reset();
        do_step("R3 jump", 16'h1654, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R3 self jump halts", 16'h1654, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R3 halted ignores step", 16'h6000, 8'h00, 8'h00, 8'h00, 16'h0);
        do_step("R3 halted ignores call", 16'h2222, 8'h00, 8'h00, 8'h00, 16'h0);

        // random stream (R2 R4 R5 R6 R9 R10 R11 mixed)
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ri;
            logic [7:0] rx;
            ri = rand_insn();
            rx = 8'($urandom);
            do_step("R2 random stream", ri, rx,
                    ($urandom % 2 == 0) ? rx : 8'($urandom),
                    8'($urandom), 16'($urandom));
        end
        finish_up();
    end
endmodule